// File: doc/BRIEF.md
# Serial Register Access Slave

This block lets an external host read and write an on-chip register bank over a four-wire synchronous serial link. The four wires are an active-low select, a serial clock, a host-to-slave data line and a slave-to-host reply line. The serial inputs are oversampled by the system clock through a synchroniser chain, and clock edges are detected in the system clock domain.

Every transaction starts with an address byte. Its leading bit chooses the direction, and the other seven bits give the register index. One data byte follows. On a write, the block pulses a one-cycle strobe on the parallel register-file port. On a read, it fetches the addressed register and shifts it out on the reply line, most significant bit first. The reply line is driven only while read data is being returned.

The register file sits outside this block. It answers `rf_rdata` combinationally from `rf_addr`.

Top module: `serreg_slave`

## Requirements
- R1: While `sel_n` is low, each rising edge of `sclk` captures one bit of `sdi`. Bytes arrive most significant bit first. Bit 7 of the first byte is the direction (1 = write, 0 = read), and bits 6..0 of that byte are the register index.
- R2: When `sel_n` goes high, the bit count returns to zero and the transaction is abandoned. A write cut off before its sixteenth bit produces no strobe and leaves the register unchanged.
- R3: On a complete write, `rf_we` is high for exactly one system clock cycle after the sixteenth bit is captured. During that cycle `rf_addr` holds the index and `rf_wdata` holds the data byte.
- R4: On a read, `rf_addr` presents the index once the eighth bit is captured, and `rf_rdata` is latched one cycle later. The byte then appears on `sdo` MSB first. Bit 7 is ready before the ninth rising edge, and each later bit changes only on a falling `sclk` edge, so the value holds while `sclk` is high.
- R5: `sdo_oe` is 0 and `sdo` is high-impedance during the address byte, throughout any write, and while `sel_n` is high. `sdo_oe` is 1 only in the data byte of a read.
- R6: The level of `sclk` when `sel_n` falls or rises may be either high or low. Decoding is the same in both cases.
- R7: The host may stop `sclk`, high or low, for any number of cycles between the address byte and the data byte without changing the result.
- R8: `sclk` edges after the sixteenth bit are ignored until `sel_n` rises. They cause no second strobe and no further shifting.
- R9: After reset, `sdo_oe` and `rf_we` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than `sclk` |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_n | input | 1 | Serial select, active low |
| sclk | input | 1 | Serial clock from the host |
| sdi | input | 1 | Serial data from the host |
| sdo | output | 1 | Serial reply data, high-impedance when not driven |
| sdo_oe | output | 1 | High while `sdo` is driven |
| rf_addr | output | 7 | Register index to the register file |
| rf_wdata | output | 8 | Write data to the register file |
| rf_we | output | 1 | One-cycle write strobe |
| rf_rdata | input | 8 | Register contents for `rf_addr`, combinational |

## Verification
The bench covers both idle clock levels at select edges. A design that counts the opening clock fall, or a spurious rise, shifts every field by one bit and corrupts both the index and the data.

It pauses between the bytes with the clock parked high. A design that times the bytes, or treats the pause as an edge, misdecodes the data byte.

It aborts a write after twelve bits and then reads the register back. A design that commits partial data, or leaves its counter running, is caught by the read.

It sends extra clocks after the sixteenth bit. A design that re-arms will raise a second strobe that the scoreboard does not expect. The reply enable is also checked during the address byte and during writes, where an early or wrong-direction drive would contend with the host.

// File: rtl/serreg_pkg.sv
package serreg_pkg;
   localparam int SR_ADDR_W = 7;
   localparam int SR_DATA_W = 8;

   typedef enum logic {
      SR_DIR_READ  = 1'b0,
      SR_DIR_WRITE = 1'b1
   } sr_dir_e;
endpackage

// File: rtl/serreg_sync.sv
module serreg_sync #(
   parameter int              W       = 1,
   parameter int              STAGES  = 2,
   parameter logic [W-1:0]    RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("serreg_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [W-1:0] stg [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
      end else begin
         stg[0] <= d;
         for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
      end
   end

   assign q = stg[STAGES-1];
endmodule

// File: rtl/serreg_edge.sv
module serreg_edge (
   input  logic clk,
   input  logic rst_n,
   input  logic lvl,
   output logic rise,
   output logic fall
);
   logic lvl_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lvl_d <= 1'b0;
      else        lvl_d <= lvl;
   end

   assign rise = lvl & ~lvl_d;
   assign fall = ~lvl & lvl_d;
endmodule

// File: rtl/serreg_frame.sv
module serreg_frame #(
   parameter int ADDR_W = 7,
   parameter int DATA_W = 8,
   localparam int ABYTE = ADDR_W + 1,
   localparam int FRAME = ABYTE + DATA_W,
   localparam int CNT_W = $clog2(FRAME + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              active,
   input  logic              rise,
   input  logic              sdi,
   output logic [CNT_W-1:0]  cnt,
   output logic [ADDR_W-1:0] addr_q,
   output logic [DATA_W-1:0] data_q,
   output logic              dir_wr,
   output logic              addr_done,
   output logic              wr_done
);
   localparam int SH_W = ((ABYTE - 1) > (DATA_W - 1)) ? (ABYTE - 1) : (DATA_W - 1);
   localparam logic [CNT_W-1:0] LAST_A = CNT_W'(ABYTE - 1);
   localparam logic [CNT_W-1:0] LAST_D = CNT_W'(FRAME - 1);
   localparam logic [CNT_W-1:0] FULL   = CNT_W'(FRAME);

   generate
      if (ADDR_W < 2 || DATA_W < 2) begin : g_bad_widths
         $error("serreg_frame: ADDR_W and DATA_W must be at least 2");
      end
   endgenerate

   logic [SH_W-1:0] sh;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt       <= '0;
         sh        <= '0;
         addr_q    <= '0;
         data_q    <= '0;
         dir_wr    <= 1'b0;
         addr_done <= 1'b0;
         wr_done   <= 1'b0;
      end else if (!active) begin
         cnt       <= '0;
         sh        <= '0;
         dir_wr    <= 1'b0;
         addr_done <= 1'b0;
         wr_done   <= 1'b0;
      end else begin
         addr_done <= 1'b0;
         wr_done   <= 1'b0;
         if (rise && cnt < FULL) begin
            sh  <= {sh[SH_W-2:0], sdi};
            cnt <= cnt + 1'b1;
            if (cnt == LAST_A) begin
               dir_wr    <= sh[ABYTE-2];
               addr_q    <= {sh[ADDR_W-2:0], sdi};
               addr_done <= 1'b1;
            end
            if (cnt == LAST_D) begin
               data_q  <= {sh[DATA_W-2:0], sdi};
               wr_done <= dir_wr;
            end
         end
      end
   end

   a_r2_select_clears: assert property (@(posedge clk) disable iff (!rst_n)
      !active |=> (cnt == '0));
   a_r8_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= FULL);
   a_r3_we_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      wr_done |=> !wr_done);
   a_r3_we_after_last_bit: assert property (@(posedge clk) disable iff (!rst_n)
      wr_done |-> (cnt == FULL));
endmodule

// File: rtl/serreg_reply.sv
module serreg_reply #(
   parameter int DATA_W = 8,
   parameter int ABYTE  = 8,
   localparam int FRAME = ABYTE + DATA_W,
   localparam int CNT_W = $clog2(FRAME + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              active,
   input  logic              load,
   input  logic              dir_wr,
   input  logic              sclk_lvl,
   input  logic              fall,
   input  logic [CNT_W-1:0]  cnt,
   input  logic [DATA_W-1:0] rdata,
   output logic              bit_out,
   output logic              oe
);
   localparam logic [CNT_W-1:0] FIRST = CNT_W'(ABYTE);
   localparam logic [CNT_W-1:0] FULL  = CNT_W'(FRAME);

   logic [DATA_W-1:0] sh_o;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_o <= '0;
         oe   <= 1'b0;
      end else if (!active) begin
         sh_o <= '0;
         oe   <= 1'b0;
      end else if (load && !dir_wr) begin
         sh_o <= rdata;
         oe   <= 1'b1;
      end else if (fall && oe && cnt > FIRST && cnt < FULL) begin
         sh_o <= {sh_o[DATA_W-2:0], 1'b0};
      end
   end

   assign bit_out = sh_o[DATA_W-1];

   a_r4_hold_while_high: assert property (@(posedge clk) disable iff (!rst_n)
      (sclk_lvl && $past(sclk_lvl) && oe && $past(oe)) |-> $stable(bit_out));
   a_r5_no_drive_in_addr: assert property (@(posedge clk) disable iff (!rst_n)
      oe |-> (cnt >= FIRST));
endmodule

// File: rtl/serreg_slave.sv
module serreg_slave
   import serreg_pkg::*;
#(
   parameter int ADDR_W      = SR_ADDR_W,
   parameter int DATA_W      = SR_DATA_W,
   parameter int SYNC_STAGES = 2,
   localparam int ABYTE = ADDR_W + 1,
   localparam int FRAME = ABYTE + DATA_W,
   localparam int CNT_W = $clog2(FRAME + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sel_n,
   input  logic              sclk,
   input  logic              sdi,
   output logic              sdo,
   output logic              sdo_oe,
   output logic [ADDR_W-1:0] rf_addr,
   output logic [DATA_W-1:0] rf_wdata,
   output logic              rf_we,
   input  logic [DATA_W-1:0] rf_rdata
);
   logic [2:0] pins_s;
   logic       sel_s, sclk_s, sdi_s;
   logic       rise, fall;
   logic [CNT_W-1:0] cnt;
   logic       dir_wr, addr_done, wr_done;
   logic       bit_out, oe;

   serreg_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) i_sync (
      .clk(clk), .rst_n(rst_n), .d({sel_n, sclk, sdi}), .q(pins_s));

   assign sel_s  = pins_s[2];
   assign sclk_s = pins_s[1];
   assign sdi_s  = pins_s[0];

   serreg_edge i_edge (
      .clk(clk), .rst_n(rst_n), .lvl(sclk_s), .rise(rise), .fall(fall));

   serreg_frame #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_frame (
      .clk(clk), .rst_n(rst_n), .active(!sel_s), .rise(rise), .sdi(sdi_s),
      .cnt(cnt), .addr_q(rf_addr), .data_q(rf_wdata), .dir_wr(dir_wr),
      .addr_done(addr_done), .wr_done(wr_done));

   serreg_reply #(.DATA_W(DATA_W), .ABYTE(ABYTE)) i_reply (
      .clk(clk), .rst_n(rst_n), .active(!sel_s), .load(addr_done),
      .dir_wr(dir_wr), .sclk_lvl(sclk_s), .fall(fall), .cnt(cnt),
      .rdata(rf_rdata), .bit_out(bit_out), .oe(oe));

   assign rf_we  = wr_done;
   assign sdo_oe = oe;
   assign sdo    = oe ? bit_out : 1'bz;

   a_r5_no_drive_on_write: assert property (@(posedge clk) disable iff (!rst_n)
      rf_we |-> !sdo_oe);
   a_r5_quiet_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
      sel_s |=> !sdo_oe);
endmodule

// File: tb/test_serreg_slave.sv
module test_serreg_slave;
   localparam int CLK_PERIOD = 10;
   localparam int H = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sel_n = 1'b1;
   logic sclk = 1'b0;
   logic sdi = 1'b0;
   logic sdo, sdo_oe, rf_we;
   logic [6:0] rf_addr;
   logic [7:0] rf_wdata, rf_rdata;

   int n_tests = 0;
   int n_fail  = 0;

   typedef struct { logic [6:0] a; logic [7:0] d; } wr_t;
   wr_t exp_q [$];

   logic [7:0] bank    [128];
   logic [7:0] exp_mem [128];

   always #(CLK_PERIOD/2) clk = ~clk;

   serreg_slave i_serreg_slave (
      .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .sclk(sclk), .sdi(sdi),
      .sdo(sdo), .sdo_oe(sdo_oe), .rf_addr(rf_addr), .rf_wdata(rf_wdata),
      .rf_we(rf_we), .rf_rdata(rf_rdata));

   assign rf_rdata = bank[rf_addr];
   always @(posedge clk) if (rf_we) bank[rf_addr] <= rf_wdata;

   function automatic logic [7:0] seed(int i);
      return 8'(i * 37 + 11);
   endfunction

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // scoreboard monitor: each strobe must match the oldest queued write (R3)
   always @(negedge clk) begin
      if (rst_n && rf_we === 1'b1) begin
         if (exp_q.size() == 0) begin
            chk(1'b0, "R2/R8", "unexpected write strobe", rf_addr, 0);
         end else begin
            wr_t e;
            e = exp_q.pop_front();
            chk(rf_addr == e.a, "R3", "strobe address", rf_addr, e.a);
            chk(rf_wdata == e.d, "R3", "strobe data", rf_wdata, e.d);
         end
      end
   end

   task automatic xfer(input bit wr, input logic [6:0] a, input logic [7:0] d,
                       input int nbits, input bit idle_hi, input int gap,
                       input int extra, output logic [7:0] rd, output bit quiet);
      logic [7:0] ab;
      ab = {wr, a};
      rd = '0;
      quiet = 1'b1;
      sclk = idle_hi;
      repeat (4) @(negedge clk);
      sel_n = 1'b0;
      repeat (4) @(negedge clk);
      for (int i = 0; i < nbits + extra; i++) begin
         if (i == 8) repeat (gap) @(negedge clk);
         sclk = 1'b0;
         sdi = (i < 8) ? ab[7-i] : ((i < 16) ? d[15-i] : 1'b0);
         repeat (H) @(negedge clk);
         if (i < 8 && sdo_oe !== 1'b0) quiet = 1'b0;
         sclk = 1'b1;
         repeat (H/2) @(negedge clk);
         if (i >= 8 && i < 16 && !wr) rd[15-i] = sdo;
         if (wr && sdo_oe !== 1'b0) quiet = 1'b0;
         repeat (H/2) @(negedge clk);
      end
      sclk = idle_hi;
      repeat (4) @(negedge clk);
      sel_n = 1'b1;
      repeat (6) @(negedge clk);
   endtask

   task automatic do_write(input logic [6:0] a, input logic [7:0] d,
                           input bit idle_hi, input int gap, input int extra);
      logic [7:0] rd;
      bit quiet;
      wr_t e;
      e.a = a; e.d = d;
      exp_q.push_back(e);
      exp_mem[a] = d;
      xfer(1'b1, a, d, 16, idle_hi, gap, extra, rd, quiet);
      chk(quiet, "R5", "reply driven during write", 1, 0);
      chk(sdo_oe == 1'b0, "R5", "reply enable after select rise", sdo_oe, 0);
   endtask

   task automatic do_read(input logic [6:0] a, input bit idle_hi,
                          input int gap, input int extra, input string req);
      logic [7:0] rd;
      bit quiet;
      xfer(1'b0, a, 8'h00, 16, idle_hi, gap, extra, rd, quiet);
      chk(quiet, "R5", "reply driven during address byte", 1, 0);
      chk(rd == exp_mem[a], req, "read data", rd, exp_mem[a]);
      chk(sdo_oe == 1'b0, "R5", "reply enable after select rise", sdo_oe, 0);
   endtask

   initial begin
      logic [7:0] rd;
      bit quiet;
      for (int i = 0; i < 128; i++) begin
         bank[i] = seed(i);
         exp_mem[i] = seed(i);
      end
      repeat (5) @(negedge clk);
      chk(sdo_oe == 1'b0, "R9", "reply enable in reset", sdo_oe, 0);
      chk(rf_we == 1'b0, "R9", "strobe in reset", rf_we, 0);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);
      chk(sdo_oe == 1'b0, "R9", "reply enable after reset", sdo_oe, 0);

      // R1 R3 basic writes with both idle levels (R6), pause (R7), extras (R8)
      do_write(7'h00, 8'hA5, 1'b0, 0, 0);
      do_write(7'h7F, 8'h3C, 1'b1, 0, 0);
      do_write(7'h15, 8'hFF, 1'b0, 50, 0);
      do_write(7'h2A, 8'h00, 1'b1, 0, 5);
      do_write(7'h41, 8'h96, 1'b0, 0, 0);

      // R4 reads back, varied patterns
      do_read(7'h00, 1'b0, 0, 0, "R4");
      do_read(7'h7F, 1'b1, 0, 0, "R6");
      do_read(7'h15, 1'b0, 0, 0, "R1");
      do_read(7'h2A, 1'b0, 40, 0, "R7");
      do_read(7'h41, 1'b1, 30, 0, "R7");
      do_read(7'h63, 1'b0, 0, 4, "R8");

      // R2 abort: partial write then readback unchanged
      xfer(1'b1, 7'h15, 8'h11, 12, 1'b0, 0, 0, rd, quiet);
      do_read(7'h15, 1'b0, 0, 0, "R2");
      // R2 abort read after address byte, then a normal write still works
      xfer(1'b0, 7'h41, 8'h00, 8, 1'b1, 0, 0, rd, quiet);
      chk(sdo_oe == 1'b0, "R2", "reply enable after aborted read", sdo_oe, 0);
      do_write(7'h41, 8'h5A, 1'b1, 10, 3);
      do_read(7'h41, 1'b0, 0, 0, "R3");

      repeat (20) @(negedge clk);
      chk(exp_q.size() == 0, "R3", "writes not strobed", exp_q.size(), 0);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule